// File: doc/BRIEF.md
# Dual-Mode Privilege Controller

This block keeps the processor's privilege state: one mode bit (system or user), an interrupt-enable flag and a saved copy of the mode that was active when the last trap was taken. Each cycle it looks at the class of the instruction being issued, which a decoder outside the block supplies, and at a pending interrupt request. It decides whether the instruction may take effect, whether a trap is taken, and which vector-table slot the fetch unit should use next.

User code cannot enter system mode on its own. System mode is reached only through a trap. A trap is either an accepted interrupt or a privilege violation, which occurs when a restricted instruction is issued in user mode. Every instruction that touches the mode bit or the interrupt settings is restricted, so user code cannot mask interrupts. When a violation and an interrupt occur in the same cycle, the violation is served first and the interrupt is kept for later.

Top module: `priv_mode_ctrl`

## Requirements
- R1: While reset is held and right after it, the mode output is 0, which means system mode (user mode is 1). The interrupt-enable output and the saved-mode output are also 0.
- R2: Instruction classes are 0 normal, 1 privileged, 2 set-mode, 3 return-to-user and 4 interrupt-config. Classes 5 to 7 are treated as privileged. A valid instruction of any class other than 0 issued in user mode has no effect. In that same cycle trap_o is 1, the cause is 1 and vec_idx_o equals TRAP_VEC (default 0). The mode is 0 after the next clock edge.
- R3: A valid set-mode instruction in system mode loads insn_arg into the mode bit at the next clock edge.
- R4: A valid return-to-user instruction in system mode sets the mode bit to 1 at the next clock edge.
- R5: A valid interrupt-config instruction in system mode loads insn_arg into the interrupt-enable flag at the next clock edge. In user mode the flag is left unchanged.
- R6: When the interrupt-enable flag is 1 and a request is present (live or pending), and there is no violation, the interrupt is accepted. In that cycle trap_o is 1, the cause is 2 and vec_idx_o carries the request's vector. Any instruction issued in that cycle is dropped, and the mode is 0 after the next edge.
- R7: A request that is not accepted is held as pending, together with its vector, until it is accepted. While a request is pending, new requests and their vectors are ignored.
- R8: If a violation and an acceptable interrupt occur in the same cycle, only the violation trap is taken (cause 1). The interrupt stays pending and can be accepted in a later cycle.
- R9: On every trap the mode that was active before the trap is saved. prev_mode_o shows the saved value while in system mode and reads 0 while in user mode.
- R10: When no trap is taken, trap_o, the cause and vec_idx_o are 0. A normal instruction or no valid instruction leaves the mode and the interrupt-enable flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | An instruction is issued this cycle |
| insn_class | input | 3 | Decoded instruction class |
| insn_arg | input | 1 | Operand for set-mode and interrupt-config |
| irq_req | input | 1 | Interrupt request |
| irq_vec | input | VEC_W | Vector number of the request |
| mode_o | output | 1 | Current mode, 0 system, 1 user |
| int_en_o | output | 1 | Interrupt-enable flag |
| prev_mode_o | output | 1 | Mode saved at the last trap, visible in system mode |
| trap_o | output | 1 | A trap is taken this cycle |
| trap_cause_o | output | CAUSE_W | 0 none, 1 privilege violation, 2 interrupt |
| vec_idx_o | output | VEC_W | Vector-table slot for the trap |

## Verification
Directed sequences issue every instruction class once in system mode and once in user mode. This separates the classes that execute from those that must trap, and it shows that user code cannot change the enable flag. Requests are raised while interrupts are disabled, and a second request with a different vector follows. When the enabled delivery occurs, the vector it carries shows whether the first vector was kept and the later one dropped. A violation issued in the same cycle as a request tells the priority apart from the pending path. A long stretch of random classes, operands and requests is then compared cycle by cycle against a behavioural model.

// File: rtl/privctl_pkg.sv
package privctl_pkg;

  typedef enum logic [2:0] {
    IC_NORMAL  = 3'd0,
    IC_PRIV    = 3'd1,
    IC_SETMODE = 3'd2,
    IC_RETUSER = 3'd3,
    IC_INTCFG  = 3'd4
  } iclass_e;

  localparam logic MODE_SYS = 1'b0;
  localparam logic MODE_USR = 1'b1;

  // Any class except normal needs system mode, reserved codes included.
  function automatic logic needs_system(input logic [2:0] cls);
    return cls != IC_NORMAL;
  endfunction

  function automatic logic is_violation(input logic valid, input logic mode,
                                        input logic [2:0] cls);
    return valid && (mode == MODE_USR) && needs_system(cls);
  endfunction

endpackage

// File: rtl/priv_viol_det.sv
module priv_viol_det
  import privctl_pkg::*;
(
  input  logic       valid,
  input  logic       mode,
  input  logic [2:0] cls,
  output logic       viol,
  output logic       do_setmode,
  output logic       do_retuser,
  output logic       do_intcfg
);
  logic sys_issue;

  always_comb begin
    viol      = is_violation(valid, mode, cls);
    sys_issue = valid && (mode == MODE_SYS);
    do_setmode = sys_issue && (cls == IC_SETMODE);
    do_retuser = sys_issue && (cls == IC_RETUSER);
    do_intcfg  = sys_issue && (cls == IC_INTCFG);
  end
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
  parameter int VEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             take,
  output logic             req_eff,
  output logic [VEC_W-1:0] vec_eff,
  output logic             pend_q
);
  logic [VEC_W-1:0] pvec_q;

  always_comb begin
    req_eff = pend_q || irq_req;
    vec_eff = pend_q ? pvec_q : irq_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pvec_q <= '0;
    end else if (take) begin
      pend_q <= 1'b0;
    end else if (!pend_q && irq_req) begin
      pend_q <= 1'b1;
      pvec_q <= irq_vec;
    end
  end
endmodule

// File: rtl/mode_regs.sv
module mode_regs
  import privctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enter_trap,
  input  logic exec_ok,
  input  logic do_setmode,
  input  logic do_retuser,
  input  logic do_intcfg,
  input  logic arg,
  output logic mode_q,
  output logic prev_q,
  output logic ien_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SYS;
      prev_q <= MODE_SYS;
      ien_q  <= 1'b0;
    end else if (enter_trap) begin
      prev_q <= mode_q;
      mode_q <= MODE_SYS;
    end else if (exec_ok) begin
      if (do_setmode) mode_q <= arg;
      if (do_retuser) mode_q <= MODE_USR;
      if (do_intcfg)  ien_q  <= arg;
    end
  end
endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
  import privctl_pkg::*;
#(
  parameter int VEC_W    = 4,
  parameter int CAUSE_W  = 2,
  parameter int TRAP_VEC = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insn_valid,
  input  logic [2:0]         insn_class,
  input  logic               insn_arg,
  input  logic               irq_req,
  input  logic [VEC_W-1:0]   irq_vec,
  output logic               mode_o,
  output logic               int_en_o,
  output logic               prev_mode_o,
  output logic               trap_o,
  output logic [CAUSE_W-1:0] trap_cause_o,
  output logic [VEC_W-1:0]   vec_idx_o
);
  localparam logic [CAUSE_W-1:0] CAUSE_NONE = CAUSE_W'(0);
  localparam logic [CAUSE_W-1:0] CAUSE_PRIV = CAUSE_W'(1);
  localparam logic [CAUSE_W-1:0] CAUSE_IRQ  = CAUSE_W'(2);
  localparam logic [VEC_W-1:0]   TRAP_IDX   = VEC_W'(TRAP_VEC);

  logic             mode_q, prev_q, ien_q;
  logic             priv_viol, do_setmode, do_retuser, do_intcfg;
  logic             req_eff, irq_pend, irq_take;
  logic [VEC_W-1:0] vec_eff;

  priv_viol_det u_det (
    .valid      (insn_valid),
    .mode       (mode_q),
    .cls        (insn_class),
    .viol       (priv_viol),
    .do_setmode (do_setmode),
    .do_retuser (do_retuser),
    .do_intcfg  (do_intcfg)
  );

  irq_pend_unit #(.VEC_W(VEC_W)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .take    (irq_take),
    .req_eff (req_eff),
    .vec_eff (vec_eff),
    .pend_q  (irq_pend)
  );

  // Violation outranks the interrupt; the interrupt then stays pending.
  assign irq_take = req_eff && ien_q && !priv_viol;

  mode_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_trap (priv_viol || irq_take),
    .exec_ok    (!irq_take),
    .do_setmode (do_setmode),
    .do_retuser (do_retuser),
    .do_intcfg  (do_intcfg),
    .arg        (insn_arg),
    .mode_q     (mode_q),
    .prev_q     (prev_q),
    .ien_q      (ien_q)
  );

  always_comb begin
    trap_o       = priv_viol || irq_take;
    trap_cause_o = CAUSE_NONE;
    vec_idx_o    = '0;
    if (priv_viol) begin
      trap_cause_o = CAUSE_PRIV;
      vec_idx_o    = TRAP_IDX;
    end else if (irq_take) begin
      trap_cause_o = CAUSE_IRQ;
      vec_idx_o    = vec_eff;
    end
  end

  assign mode_o      = mode_q;
  assign int_en_o    = ien_q;
  assign prev_mode_o = (mode_q == MODE_SYS) ? prev_q : 1'b0;

endmodule

// File: rtl/priv_mode_ctrl_chk.sv
module priv_mode_ctrl_chk #(
  parameter int VEC_W   = 4,
  parameter int CAUSE_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               insn_valid,
  input logic [2:0]         insn_class,
  input logic               insn_arg,
  input logic               irq_req,
  input logic               mode_o,
  input logic               int_en_o,
  input logic               trap_o,
  input logic [CAUSE_W-1:0] trap_cause_o,
  input logic               viol,
  input logic               irq_take,
  input logic               pend,
  input logic               prev_q
);
  a_r1_reset_sys: assert property (@(posedge clk)
    !rst_n |=> (mode_o == 1'b0 && int_en_o == 1'b0));

  a_r2_viol_enters_sys: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> (mode_o == 1'b0 && prev_q == 1'b1));

  a_r2_viol_cause: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (trap_o && trap_cause_o == CAUSE_W'(1)));

  a_r4_ret_user: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !mode_o && insn_class == 3'd3 && !irq_take) |=> mode_o);

  a_r5_user_keeps_ien: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o |=> $stable(int_en_o));

  a_r3_user_entry_only_by_insn: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_o && !(insn_valid && (insn_class == 3'd2 && insn_arg || insn_class == 3'd3)))
      |=> !mode_o);

  a_r6_irq_to_sys: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (mode_o == 1'b0));

  a_r8_priority: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> !irq_take);

  a_r8_irq_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && (irq_req || pend)) |=> pend);

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(viol || irq_take) |-> (!trap_o && trap_cause_o == '0));
endmodule

bind priv_mode_ctrl priv_mode_ctrl_chk #(.VEC_W(VEC_W), .CAUSE_W(CAUSE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .insn_valid   (insn_valid),
  .insn_class   (insn_class),
  .insn_arg     (insn_arg),
  .irq_req      (irq_req),
  .mode_o       (mode_o),
  .int_en_o     (int_en_o),
  .trap_o       (trap_o),
  .trap_cause_o (trap_cause_o),
  .viol         (priv_viol),
  .irq_take     (irq_take),
  .pend         (irq_pend),
  .prev_q       (prev_q)
);

// File: tb/priv_mode_ctrl_tb.sv
module priv_mode_ctrl_tb;
  localparam int VEC_W = 4;
  localparam int CAUSE_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_valid = 1'b0;
  logic [2:0] insn_class = 3'd0;
  logic insn_arg = 1'b0;
  logic irq_req = 1'b0;
  logic [VEC_W-1:0] irq_vec = '0;
  logic mode_o, int_en_o, prev_mode_o, trap_o;
  logic [CAUSE_W-1:0] trap_cause_o;
  logic [VEC_W-1:0] vec_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_mode = 0, m_ien = 0, m_prev = 0, m_pend = 0, m_pvec = 0;

  always #5 clk = ~clk;

  priv_mode_ctrl #(.VEC_W(VEC_W), .CAUSE_W(CAUSE_W), .TRAP_VEC(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_class(insn_class),
    .insn_arg(insn_arg), .irq_req(irq_req), .irq_vec(irq_vec),
    .mode_o(mode_o), .int_en_o(int_en_o), .prev_mode_o(prev_mode_o),
    .trap_o(trap_o), .trap_cause_o(trap_cause_o), .vec_idx_o(vec_idx_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input int cls, input bit arg, input bit req,
                      input int vec, input string tag);
    int viol, take, evec, e_cause, e_vec;
    @(negedge clk);
    insn_valid = v; insn_class = 3'(cls); insn_arg = arg;
    irq_req = req; irq_vec = VEC_W'(vec);
    #1;
    viol = (v && m_mode == 1 && cls != 0) ? 1 : 0;
    evec = m_pend ? m_pvec : vec;
    take = ((m_pend || req) && m_ien && !viol) ? 1 : 0;
    e_cause = viol ? 1 : (take ? 2 : 0);
    e_vec = viol ? 0 : (take ? evec : 0);
    chk(tag, "mode", mode_o, m_mode);
    chk(tag, "int_en", int_en_o, m_ien);
    chk(tag, "prev_mode", prev_mode_o, (m_mode == 0) ? m_prev : 0);
    chk(tag, "trap", trap_o, (viol || take) ? 1 : 0);
    chk(tag, "cause", trap_cause_o, e_cause);
    chk(tag, "vec_idx", vec_idx_o, e_vec);
    @(posedge clk);
    if (viol || take) begin
      m_prev = m_mode;
      m_mode = 0;
    end else if (v && m_mode == 0) begin
      if (cls == 2) m_mode = arg;
      if (cls == 3) m_mode = 1;
      if (cls == 4) m_ien = arg;
    end
    if (take) m_pend = 0;
    else if (!m_pend && req) begin
      m_pend = 1;
      m_pvec = vec;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "mode in reset", mode_o, 0);
    chk("R1", "int_en in reset", int_en_o, 0);
    chk("R1", "prev in reset", prev_mode_o, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "R1");
    // R10: normal and idle in system mode
    step(1, 0, 1, 0, 0, "R10");
    step(0, 3, 1, 0, 0, "R10");
    // R5: enable interrupts from system mode
    step(1, 4, 1, 0, 0, "R5");
    // R4: drop to user
    step(1, 3, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R10");
    // R2: each restricted class in user mode traps
    for (int c = 1; c < 8; c++) begin
      step(1, c, 1, 0, 0, "R2");
      step(0, 0, 0, 0, 0, "R9");
      step(1, 3, 0, 0, 0, "R4");
    end
    // R5: user attempt to disable interrupts then an interrupt still arrives (R6)
    step(1, 4, 0, 0, 0, "R5");
    step(1, 3, 0, 0, 0, "R4");
    step(1, 0, 0, 1, 9, "R6");
    step(0, 0, 0, 0, 0, "R9");
    // R3: set-mode in system mode, both values
    step(1, 2, 0, 0, 0, "R3");
    step(1, 2, 1, 0, 0, "R3");
    step(1, 2, 1, 0, 0, "R2");
    // R7: requests while disabled are held; later vector ignored
    step(1, 4, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 5, "R7");
    step(0, 0, 0, 1, 12, "R7");
    step(0, 0, 0, 0, 0, "R7");
    step(1, 4, 1, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R7");
    // R6: interrupt in system mode squashes the instruction
    step(1, 3, 0, 1, 3, "R6");
    step(0, 0, 0, 0, 0, "R6");
    // R8: violation and interrupt together
    step(1, 3, 0, 0, 0, "R4");
    step(1, 1, 0, 1, 7, "R8");
    step(0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, "R9");
    // mixed random stretch, R6 R8 R9 R10
    for (int i = 0; i < 600; i++) begin
      step(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0),
           int'($urandom_range(0, 15)), "R8 R6 R9 R10");
    end
    finish_run();
  end
endmodule